// File: doc/BRIEF.md
# Folded Vectoring CORDIC Angle Engine with Direction-Flag Stream

This block is the angle-finding element that sits on the diagonal of a parallel Jacobi eigenvalue array. Given a two-dimensional vector (x, y) in signed fixed point, it runs the CORDIC vectoring recurrence for a chosen number of iterations. It drives y toward zero and, in an angle register cleared at start, builds up the angle of the vector. The datapath is folded: one pair of adders updates the x/y plane and a third adder updates the angle. All three are reused in every iteration, and each variable has its own register between iterations.

The rotation direction chosen in each iteration is sent out as it is decided, one flag per cycle with a valid strobe. Off-diagonal rotators in the same array can then repeat the identical sequence of micro-rotations in lockstep, with no angle arithmetic of their own. A vector in the left half plane is first turned by half a turn and the angle register starts at half a turn, so the result covers the whole circle. An optional pass after the iterations multiplies the final magnitude by the inverse CORDIC gain. It adds one shifted copy of x per cycle, so it needs no multiplier.

Top module: `cordicVecPe`

## Requirements
- R1: After reset `doneOut`, `flagValid` and `dirFlag` are low and `angleOut` and `magOut` are zero.
- R2: Angles are unsigned AW-bit binary fractions of a full turn (2^AW = 2π). When the start edge samples `xIn` ≥ 0, the angle register starts at 0 and x, y start at `xIn`, `yIn`. When `xIn` < 0, they start at −`xIn`, −`yIn`, and the angle register starts at 2^(AW−1) (half a turn).
- R3: Iteration i (i = 0,1,…) has a direction d = 1 when x and y have the same sign bit (zero counts as non-negative), and d = 0 otherwise. For d = 1: x += y>>>i, y −= x>>>i, angle += c_i. For d = 0: x −= y>>>i, y += x>>>i, angle −= c_i. Here >>> is an arithmetic shift of the old values and c_i = round(atan(2^−i)·2^AW/2π).
- R4: `flagValid` is high in exactly the n cycles that follow the start edge, and `dirFlag` carries d of iteration k in the k-th of them. `dirFlag` is low whenever `flagValid` is low.
- R5: The effective count n is `iterCnt` clamped to MAX_ITER. A count of 0 runs no iterations and emits no flags.
- R6: `doneOut` is high for exactly one cycle. Counting the edge that samples `startIn` as edge 0, it goes high after edge n when `gainEn` was 0, and after edge n+7 when `gainEn` was 1.
- R7: With `gainEn` = 1, `magOut` at done equals (x>>>1)+(x>>>3)−(x>>>6)−(x>>>9)−(x>>>13)−(x>>>15)−(x>>>16), where x is the final x. With `gainEn` = 0 it equals the final x.
- R8: `angleOut` and `magOut` hold their done-cycle values until the next accepted start.
- R9: `startIn` is ignored from the accepted start edge up to and including the done cycle.
- R10: During iterations the x value never decreases, and the final magnitude is non-negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Start strobe, sampled while idle |
| xIn | input | W | Signed x component |
| yIn | input | W | Signed y component |
| iterCnt | input | $clog2(MAX_ITER+1) | Requested iteration count |
| gainEn | input | 1 | Run the gain-correction pass after the iterations |
| angleOut | output | AW | Accumulated angle, fraction of a full turn |
| magOut | output | W+2 | Final x, gain-corrected when requested |
| dirFlag | output | 1 | Direction of the current iteration |
| flagValid | output | 1 | Marks a cycle carrying a direction flag |
| doneOut | output | 1 | One-cycle completion pulse |

## Verification
The start strobe is sampled at edge 0. Flag k is due in the cycle after edge k, for k below the clamped count n. `doneOut`, the angle and the magnitude are due after edge n, or after edge n+7 when the gain pass is on. The bench samples every output on the falling edge and steps a cycle index from edge 0. In each cycle it compares the valid strobe, the flag and the done pulse with what an independent model of the recurrence predicts for that index. It also checks that a start pulsed mid-run or in the done cycle leaves both the flag stream and the held results unchanged.

// File: rtl/cordicVecPkg.sv
package cordicVecPkg;

  // Number of shift-add terms in the gain-correction pass
  localparam int SCALE_TERMS = 7;
  localparam int SCW = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_SCALE,
    ST_FIN
  } peState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // capture inputs, pre-rotate
    logic step;     // apply one micro-rotation
    logic dir;      // direction of that micro-rotation
    logic scale;    // apply one gain-correction term
    logic useGain;  // magnitude port shows the corrected value
  } ctrlStrobe_t;

  // Shift of each gain-correction term
  function automatic logic [4:0] scaleShift(logic [SCW-1:0] k);
    case (k)
      3'd0: return 5'd1;
      3'd1: return 5'd3;
      3'd2: return 5'd6;
      3'd3: return 5'd9;
      3'd4: return 5'd13;
      3'd5: return 5'd15;
      default: return 5'd16;
    endcase
  endfunction

  // Sign of each gain-correction term (1 = subtract)
  function automatic logic scaleNeg(logic [SCW-1:0] k);
    return (k >= 3'd2);
  endfunction

endpackage

// File: rtl/cordicVecCtrl.sv
module cordicVecCtrl
  import cordicVecPkg::*;
#(
  parameter int MAX_ITER = 32,
  parameter int CW = $clog2(MAX_ITER + 1),
  parameter int IW = (MAX_ITER > 1) ? $clog2(MAX_ITER) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [CW-1:0]    iterCnt,
  input  logic             gainEn,
  input  logic             xSign,
  input  logic             ySign,
  output ctrlStrobe_t      strobe,
  output logic [IW-1:0]    iterIdx,
  output logic [SCW-1:0]   scaleIdx,
  output logic             flagValid,
  output logic             dirFlag,
  output logic             doneOut
);

  peState_t      state;
  logic [CW-1:0] nLat;
  logic          gainLat;
  logic [CW-1:0] nClamp;
  logic          lastIter;
  logic          lastScale;

  assign nClamp    = (iterCnt > CW'(MAX_ITER)) ? CW'(MAX_ITER) : iterCnt;
  assign lastIter  = (CW'(iterIdx) == (nLat - CW'(1)));
  assign lastScale = (scaleIdx == SCW'(SCALE_TERMS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      nLat     <= '0;
      gainLat  <= 1'b0;
      iterIdx  <= '0;
      scaleIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startIn) begin
            nLat     <= nClamp;
            gainLat  <= gainEn;
            iterIdx  <= '0;
            scaleIdx <= '0;
            if (nClamp == '0) state <= gainEn ? ST_SCALE : ST_FIN;
            else              state <= ST_RUN;
          end
        end
        ST_RUN: begin
          iterIdx <= iterIdx + IW'(1);
          if (lastIter) state <= gainLat ? ST_SCALE : ST_FIN;
        end
        ST_SCALE: begin
          scaleIdx <= scaleIdx + SCW'(1);
          if (lastScale) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Direction: drive y toward zero, taken from the register signs
  always_comb begin
    strobe.load    = (state == ST_IDLE) && startIn;
    strobe.step    = (state == ST_RUN);
    strobe.dir     = ~(xSign ^ ySign);
    strobe.scale   = (state == ST_SCALE);
    strobe.useGain = gainLat;
  end

  assign flagValid = strobe.step;
  assign dirFlag   = strobe.step & strobe.dir;
  assign doneOut   = (state == ST_FIN);

endmodule

// File: rtl/cordicVecDatapath.sv
module cordicVecDatapath
  import cordicVecPkg::*;
#(
  parameter int W = 16,
  parameter int AW = 24,
  parameter int MAX_ITER = 32,
  parameter int XW = W + 2,
  parameter int IW = (MAX_ITER > 1) ? $clog2(MAX_ITER) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic [IW-1:0]         iterIdx,
  input  logic [SCW-1:0]        scaleIdx,
  input  logic signed [W-1:0]   xIn,
  input  logic signed [W-1:0]   yIn,
  output logic                  xSign,
  output logic                  ySign,
  output logic [AW-1:0]         angleOut,
  output logic signed [XW-1:0]  magOut
);

  localparam int SHW = (IW > 5) ? IW : 5;
  localparam logic [AW-1:0] HALF_TURN = {1'b1, {(AW-1){1'b0}}};

  // Rounded atan(2^-idx) in units of 2^-AW turns, from an exact power-of-two series
  function automatic logic [AW-1:0] stepConst(int idx);
    longint unsigned piQ;
    longint unsigned val;
    longint unsigned term;
    longint unsigned div;
    piQ = 64'h3243_F6A8_885A_308D;  // pi scaled by 2^60
    if (idx == 0) begin
      val = piQ >> 2;
    end else begin
      val = 64'd0;
      for (int k = 0; (2 * k + 1) * idx <= 60; k++) begin
        term = (64'd1 << (60 - (2 * k + 1) * idx)) / longint'(2 * k + 1);
        if ((k % 2) == 0) val = val + term;
        else              val = val - term;
      end
    end
    div = (piQ << 1) >> AW;
    return AW'((val + (div >> 1)) / div);
  endfunction

  logic [AW-1:0] stepLut [MAX_ITER];

  for (genvar g = 0; g < MAX_ITER; g++) begin : gStep
    localparam logic [AW-1:0] STEP_C = stepConst(g);
    assign stepLut[g] = STEP_C;
  end

  logic signed [XW-1:0] xR, yR, accR;
  logic [AW-1:0]        zR;
  logic signed [XW-1:0] xExt, yExt;
  logic [SHW-1:0]       shAmt;
  logic signed [XW-1:0] shX, shY;
  logic [AW-1:0]        stepVal;

  assign xExt = XW'(xIn);
  assign yExt = XW'(yIn);

  // Shared barrel shifters; the amount comes from the iteration or the scale term
  assign shAmt   = strobe.scale ? SHW'(scaleShift(scaleIdx)) : SHW'(iterIdx);
  assign shX     = xR >>> shAmt;
  assign shY     = yR >>> shAmt;
  assign stepVal = stepLut[iterIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xR   <= '0;
      yR   <= '0;
      zR   <= '0;
      accR <= '0;
    end else if (strobe.load) begin
      accR <= '0;
      if (xIn[W-1]) begin
        xR <= -xExt;
        yR <= -yExt;
        zR <= HALF_TURN;
      end else begin
        xR <= xExt;
        yR <= yExt;
        zR <= '0;
      end
    end else if (strobe.step) begin
      if (strobe.dir) begin
        xR <= xR + shY;
        yR <= yR - shX;
        zR <= zR + stepVal;
      end else begin
        xR <= xR - shY;
        yR <= yR + shX;
        zR <= zR - stepVal;
      end
    end else if (strobe.scale) begin
      if (scaleNeg(scaleIdx)) accR <= accR - shX;
      else                    accR <= accR + shX;
    end
  end

  assign xSign    = xR[XW-1];
  assign ySign    = yR[XW-1];
  assign angleOut = zR;
  assign magOut   = strobe.useGain ? accR : xR;

endmodule

// File: rtl/cordicVecPe.sv
module cordicVecPe
  import cordicVecPkg::*;
#(
  parameter int W = 16,
  parameter int AW = 24,
  parameter int MAX_ITER = 32
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                startIn,
  input  logic signed [W-1:0]                 xIn,
  input  logic signed [W-1:0]                 yIn,
  input  logic [$clog2(MAX_ITER+1)-1:0]       iterCnt,
  input  logic                                gainEn,
  output logic [AW-1:0]                       angleOut,
  output logic signed [W+1:0]                 magOut,
  output logic                                dirFlag,
  output logic                                flagValid,
  output logic                                doneOut
);

  localparam int XW = W + 2;
  localparam int CW = $clog2(MAX_ITER + 1);
  localparam int IW = (MAX_ITER > 1) ? $clog2(MAX_ITER) : 1;

  ctrlStrobe_t    strobe;
  logic [IW-1:0]  iterIdx;
  logic [SCW-1:0] scaleIdx;
  logic           xSign;
  logic           ySign;

  cordicVecCtrl #(
    .MAX_ITER(MAX_ITER),
    .CW(CW),
    .IW(IW)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .startIn(startIn),
    .iterCnt(iterCnt),
    .gainEn(gainEn),
    .xSign(xSign),
    .ySign(ySign),
    .strobe(strobe),
    .iterIdx(iterIdx),
    .scaleIdx(scaleIdx),
    .flagValid(flagValid),
    .dirFlag(dirFlag),
    .doneOut(doneOut)
  );

  cordicVecDatapath #(
    .W(W),
    .AW(AW),
    .MAX_ITER(MAX_ITER),
    .XW(XW),
    .IW(IW)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .iterIdx(iterIdx),
    .scaleIdx(scaleIdx),
    .xIn(xIn),
    .yIn(yIn),
    .xSign(xSign),
    .ySign(ySign),
    .angleOut(angleOut),
    .magOut(magOut)
  );

endmodule

// File: rtl/cordicVecPeChk.sv
module cordicVecPeChk #(
  parameter int W = 16,
  parameter int AW = 24
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [AW-1:0]        angleOut,
  input logic signed [W+1:0]  magOut,
  input logic                 dirFlag,
  input logic                 flagValid,
  input logic                 doneOut
);

  // R4
  dir_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flagValid |-> !dirFlag);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R6
  flag_before_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagValid |-> !doneOut);

  // R8
  hold_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> ($stable(angleOut) && $stable(magOut)));

  // R10
  mag_grow_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagValid |=> ($signed(magOut) >= $signed($past(magOut))));

  // R10
  mag_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> !magOut[W+1]);

endmodule

bind cordicVecPe cordicVecPeChk #(.W(W), .AW(AW)) u_chk (
  .clk(clk),
  .rstN(rstN),
  .angleOut(angleOut),
  .magOut(magOut),
  .dirFlag(dirFlag),
  .flagValid(flagValid),
  .doneOut(doneOut)
);

// File: tb/test_cordicVecPe.sv
module test_cordicVecPe;

  localparam int W = 16;
  localparam int AW = 24;
  localparam int MAX_ITER = 32;
  localparam int CW = $clog2(MAX_ITER + 1);
  localparam int XW = W + 2;
  localparam int CLK_PERIOD = 10;
  localparam real PI = 3.14159265358979323846;
  localparam longint AMASK = (64'sd1 <<< AW) - 1;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 startIn = 1'b0;
  logic signed [W-1:0]  xIn = '0;
  logic signed [W-1:0]  yIn = '0;
  logic [CW-1:0]        iterCnt = '0;
  logic                 gainEn = 1'b0;
  logic [AW-1:0]        angleOut;
  logic signed [XW-1:0] magOut;
  logic                 dirFlag;
  logic                 flagValid;
  logic                 doneOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  cordicVecPe #(.W(W), .AW(AW), .MAX_ITER(MAX_ITER)) i_cordicVecPe (
    .clk(clk), .rstN(rstN), .startIn(startIn), .xIn(xIn), .yIn(yIn),
    .iterCnt(iterCnt), .gainEn(gainEn), .angleOut(angleOut), .magOut(magOut),
    .dirFlag(dirFlag), .flagValid(flagValid), .doneOut(doneOut)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint stepRef(int i);
    real a;
    a = $atan(1.0 / (2.0 ** i));
    return longint'($floor(a / (2.0 * PI) * (2.0 ** AW) + 0.5));
  endfunction

  // Model built from R2, R3, R5 and R7
  task automatic model(input longint x0, input longint y0, input int n, input bit g,
                       output longint ang, output longint mag,
                       output logic [63:0] fl, output int ne);
    longint x, y, z, sx, sy;
    bit d;
    ne = (n > MAX_ITER) ? MAX_ITER : n;
    fl = '0;
    if (x0 < 0) begin x = -x0; y = -y0; z = 64'sd1 <<< (AW - 1); end
    else        begin x = x0;  y = y0;  z = 0; end
    for (int i = 0; i < ne; i++) begin
      d = ((x < 0) == (y < 0));
      sx = x >>> i;
      sy = y >>> i;
      if (d) begin x = x + sy; y = y - sx; z = z + stepRef(i); end
      else   begin x = x - sy; y = y + sx; z = z - stepRef(i); end
      fl[i] = d;
    end
    ang = z & AMASK;
    if (g) mag = (x >>> 1) + (x >>> 3) - (x >>> 6) - (x >>> 9) - (x >>> 13)
                 - (x >>> 15) - (x >>> 16);
    else   mag = x;
  endtask

  task automatic runOne(input int x, input int y, input int n, input bit g,
                        input bit poke, input string tag);
    longint expAng, expMag, gotAng, gotMag;
    logic [63:0] fl;
    int ne, doneAt, flagErr, doneErr;
    model(x, y, n, g, expAng, expMag, fl, ne);
    doneAt = ne + (g ? 7 : 0);
    flagErr = 0;
    doneErr = 0;
    gotAng = 0;
    gotMag = 0;
    @(negedge clk);
    xIn = W'(x); yIn = W'(y); iterCnt = CW'(n); gainEn = g; startIn = 1'b1;
    for (int k = 0; k <= doneAt; k++) begin
      @(negedge clk);
      if (k == 0) begin
        startIn = 1'b0;
        xIn = W'(-1234); yIn = W'(777);  // loaded values must not matter any more
      end
      if (flagValid !== (k < ne)) flagErr++;
      else if (k < ne && dirFlag !== fl[k]) flagErr++;
      if (doneOut !== (k == doneAt)) doneErr++;
      if (k == doneAt) begin
        gotAng = longint'(angleOut);
        gotMag = longint'(magOut);
      end
      if (poke && k == 1) startIn = 1'b1;   // mid-run start (R9)
      if (poke && k == 2) startIn = 1'b0;
      if (poke && k == doneAt) startIn = 1'b1;  // start in the done cycle (R9)
    end
    chk(flagErr == 0, "R4", {tag, " flag stream (R3 directions)"}, flagErr, 0);
    chk(doneErr == 0, "R6", {tag, " done timing"}, doneErr, 0);
    chk(gotAng == expAng, "R3", {tag, " angle"}, gotAng, expAng);
    chk(gotMag == expMag, g ? "R7" : "R10", {tag, " magnitude"}, gotMag, expMag);
    @(negedge clk);
    startIn = 1'b0;
    if (poke) chk(flagValid === 1'b0 && doneOut === 1'b0, "R9",
                  {tag, " start in busy/done cycle ignored"}, flagValid, 0);
    repeat (2) @(negedge clk);
    chk(longint'(angleOut) == gotAng && longint'(magOut) == gotMag, "R8",
        {tag, " results held"}, longint'(angleOut), gotAng);
  endtask

  task automatic angleNear(input real xr, input real yr, input string tag);
    longint e, d;
    e = longint'($floor($atan2(yr, xr) / (2.0 * PI) * (2.0 ** AW) + 0.5));
    d = (longint'(angleOut) - e) & AMASK;
    if (d >= (64'sd1 <<< (AW - 1))) d = d - (64'sd1 <<< AW);
    chk(d <= 512 && d >= -512, "R2", {tag, " angle vs atan2"}, longint'(angleOut), e & AMASK);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R6 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int x, y, n;
    bit g, p;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(doneOut === 1'b0, "R1", "reset done", doneOut, 0);
    chk(flagValid === 1'b0 && dirFlag === 1'b0, "R1", "reset flags", flagValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(angleOut === '0, "R1", "reset angle", longint'(angleOut), 0);
    chk(magOut === '0, "R1", "reset magnitude", longint'(magOut), 0);
    chk(doneOut === 1'b0 && flagValid === 1'b0, "R1", "idle after reset", doneOut, 0);

    runOne(10000, 10000, 32, 1'b0, 1'b0, "diag45");
    angleNear(10000.0, 10000.0, "diag45");
    runOne(-10000, 0, 32, 1'b0, 1'b0, "negx_axis");
    angleNear(-10000.0, 0.0, "negx_axis");
    runOne(-12000, -5000, 32, 1'b1, 1'b0, "third_quadrant");
    angleNear(-12000.0, -5000.0, "third_quadrant");
    runOne(0, 0, 32, 1'b0, 1'b0, "zero_vec");
    runOne(-32768, -32768, 32, 1'b1, 1'b0, "extreme");
    runOne(32767, -32768, 32, 1'b1, 1'b0, "extreme2");
    runOne(5, -7, 0, 1'b0, 1'b0, "R5_zero_count");
    runOne(300, 900, 0, 1'b1, 1'b0, "R5_zero_count_gain");
    runOne(1000, -3000, 45, 1'b1, 1'b0, "R5_clamp");
    runOne(20000, 3000, 12, 1'b0, 1'b1, "R9_poke");

    for (int r = 0; r < 40; r++) begin
      x = int'($urandom_range(0, 65535)) - 32768;
      y = int'($urandom_range(0, 65535)) - 32768;
      n = int'($urandom_range(0, 40));
      g = 1'($urandom_range(0, 1));
      p = ((r % 5) == 0) && (n >= 4);
      runOne(x, y, n, g, p, $sformatf("rand%0d", r));
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule